// File: doc/BRIEF.md
# MSI capture and interrupt controller

This block sits on the host side of a PCIe root port. It turns message-signalled interrupts, which downstream endpoints post as ordinary 32-bit memory writes, into a single level interrupt toward the CPU. Software programs four things through a 32-bit register port:

- a 64-bit capture address;
- a 32-bit enable vector;
- a 32-bit mask vector;
- a 32-bit pending-status vector.

Each inbound transaction is compared against the capture address. When an inbound write hits that address, the data word it carries is a vector number. That number selects one pending bit.

When a write matches, the block asserts `in_claim` in the same cycle. The surrounding fabric then drops that write instead of forwarding it to memory. Reads and non-matching accesses are never claimed, so they pass through as normal memory traffic. Software services the interrupt by reading the status vector and writing back the bits it has handled. Each written 1 flips the matching bit. Once the status vector is empty, the interrupt line drops.

Top module: `msi_irq_ctrl`

## Requirements
- R1: After reset the capture address, enable, mask and status registers all read as zero and `irq` is low.
- R2: A write to offset 0x820 replaces capture address bits 31:0 and keeps bits 63:32. A write to 0x824 replaces bits 63:32 and keeps bits 31:0. Both halves read back at the same offsets.
- R3: A captured write with data value N below 32 sets status bit N one cycle later, but only when enable bit N (offset 0x828) is 1. Data values of 32 or more leave the status unchanged.
- R4: `irq` rises in the cycle after a capture when (status AND NOT mask) is nonzero. The mask is at offset 0x82C. A capture that leaves only masked bits pending does not raise `irq`.
- R5: A write to the status offset 0x830 makes status equal to status XOR data. `irq` falls only when that result is all zero. A software write to status never raises `irq`.
- R6: No inbound write is claimed while the enable register is zero. While it is nonzero, claiming follows a rewritten capture address from the next cycle on.
- R7: Only a full-word write (`in_be` = 4'hF) to a 4-byte-aligned address equal to the capture address is claimed. Any other write is not claimed and does not change status.
- R8: Inbound reads (`in_write` = 0) are never claimed, even when they target the capture address.
- R9: Enable and mask read back as written. Reads of unmapped offsets return zero. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| in_valid | input | 1 | Inbound transaction present |
| in_write | input | 1 | 1 = memory write, 0 = memory read |
| in_addr | input | 64 | Inbound byte address |
| in_be | input | 4 | Inbound byte enables, little-endian lanes |
| in_data | input | 32 | Inbound write data |
| in_claim | output | 1 | Transaction is consumed by this block |
| irq | output | 1 | Level interrupt toward the CPU |

## Verification
The assertions assume that each inbound transaction lasts exactly one cycle while `in_valid` is high. They also assume `reg_wr` is a single-cycle strobe with stable address and data.

The assertion on status bits appearing through capture only holds in cycles without a status write. The bench never issues a register write and an inbound write in the same cycle. It drives every input on the falling edge and holds each access for exactly one cycle.

// File: rtl/msi_irq_ctrl.sv
module msi_irq_ctrl #(
  parameter int REG_AW = 12,
  parameter int DW = 32,
  parameter int BUS_AW = 64,
  parameter logic [REG_AW-1:0] OFS_ALO = 12'h820,
  parameter logic [REG_AW-1:0] OFS_AHI = 12'h824,
  parameter logic [REG_AW-1:0] OFS_EN  = 12'h828,
  parameter logic [REG_AW-1:0] OFS_MSK = 12'h82C,
  parameter logic [REG_AW-1:0] OFS_STS = 12'h830
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              in_valid,
  input  logic              in_write,
  input  logic [BUS_AW-1:0] in_addr,
  input  logic [DW/8-1:0]   in_be,
  input  logic [DW-1:0]     in_data,
  output logic              in_claim,
  output logic              irq
);
  localparam int SELW = $clog2(DW);
  localparam int HIW  = BUS_AW - DW;

  logic [BUS_AW-1:0] tgt_q;
  logic [DW-1:0] en_q, msk_q, sts_q, sts_d, cap_vec;
  logic irq_q, irq_d, aligned, in_range, sw_sts;

  assign aligned  = (in_addr[1:0] == 2'b00) && (in_be == '1);
  assign in_claim = in_valid && in_write && (en_q != '0) && aligned && (in_addr == tgt_q);
  assign in_range = (in_data[DW-1:SELW] == '0);
  assign cap_vec  = (in_claim && in_range) ? ((DW'(1) << in_data[SELW-1:0]) & en_q) : '0;
  assign sw_sts   = reg_wr && (reg_addr == OFS_STS);
  assign sts_d    = (sw_sts ? (sts_q ^ reg_wdata) : sts_q) | cap_vec;

  always_comb begin
    irq_d = irq_q;
    if (in_claim && ((sts_d & ~msk_q) != '0)) irq_d = 1'b1;
    else if (sw_sts && (sts_d == '0))         irq_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q <= '0;
      en_q  <= '0;
      msk_q <= '0;
      sts_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      irq_q <= irq_d;
      if (reg_wr) begin
        case (reg_addr)
          OFS_ALO: tgt_q[DW-1:0] <= reg_wdata;
          OFS_AHI: tgt_q[BUS_AW-1:DW] <= reg_wdata[HIW-1:0];
          OFS_EN:  en_q <= reg_wdata;
          OFS_MSK: msk_q <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_ALO: reg_rdata = tgt_q[DW-1:0];
      OFS_AHI: reg_rdata = DW'(tgt_q[BUS_AW-1:DW]);
      OFS_EN:  reg_rdata = en_q;
      OFS_MSK: reg_rdata = msk_q;
      OFS_STS: reg_rdata = sts_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = irq_q;

  p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq && sts_q == '0 && en_q == '0 && tgt_q == '0));

  p_lo_keeps_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_ALO) |=> $stable(tgt_q[BUS_AW-1:DW]));

  p_only_enabled_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_claim && !sw_sts) |=> ((sts_q & ~$past(sts_q) & ~$past(en_q)) == '0));

  p_irq_rise_on_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(in_claim));

  p_irq_needs_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_q != '0));

  p_no_decode_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !in_claim);

  p_claim_full_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_claim |-> (in_be == '1 && in_addr[1:0] == 2'b00));

  p_read_passes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_write) |-> !in_claim);
endmodule

// File: tb/tb_msi_irq_ctrl.sv
module tb_msi_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic in_valid = 1'b0, in_write = 1'b0, in_claim, irq;
  logic [63:0] in_addr = '0;
  logic [3:0] in_be = '0;
  logic [31:0] in_data = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  msi_irq_ctrl dut (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .in_valid, .in_write, .in_addr, .in_be, .in_data, .in_claim, .irq);

  localparam logic [11:0] A_LO = 12'h820, A_HI = 12'h824, A_EN = 12'h828,
                          A_MK = 12'h82C, A_ST = 12'h830;
  localparam logic [63:0] TGT = 64'h0000_0001_FEE0_1000;

  // {enable, mask, data, expected status, expected irq}
  localparam logic [128:0] VEC [0:6] = '{
    {32'hFFFF_FFFF, 32'h0000_0000, 32'd5,     32'h0000_0020, 1'b1},
    {32'h0000_0001, 32'h0000_0000, 32'd3,     32'h0000_0000, 1'b0},
    {32'hFFFF_FFFF, 32'h8000_0000, 32'd31,    32'h8000_0000, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'd32,    32'h0000_0000, 1'b0},
    {32'h0001_0000, 32'hFFFE_FFFF, 32'd16,    32'h0001_0000, 1'b1},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h100,   32'h0000_0000, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'd0,     32'h0000_0001, 1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic inj(input logic w, input logic [63:0] a, input logic [3:0] be,
                     input logic [31:0] d, output logic claim);
    @(negedge clk); in_valid = 1'b1; in_write = w; in_addr = a; in_be = be; in_data = d;
    #1 claim = in_claim;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic clear_status();
    logic [31:0] s;
    rd(A_ST, s);
    wr(A_ST, s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_LO, v); chk("R1 addr_lo", v, 0);
    rd(A_HI, v); chk("R1 addr_hi", v, 0);
    rd(A_EN, v); chk("R1 enable", v, 0);
    rd(A_MK, v); chk("R1 mask", v, 0);
    rd(A_ST, v); chk("R1 status", v, 0);
    chk("R1 irq", irq, 0);

    // R2 partial address updates
    wr(A_LO, 32'h1122_3344);
    wr(A_HI, 32'hAABB_CCDD);
    wr(A_LO, 32'h5566_7788);
    rd(A_LO, v); chk("R2 lo replaced", v, 32'h5566_7788);
    rd(A_HI, v); chk("R2 hi kept", v, 32'hAABB_CCDD);
    wr(A_HI, 32'h0000_0001);
    rd(A_LO, v); chk("R2 lo kept", v, 32'h5566_7788);
    wr(A_LO, TGT[31:0]);

    // R6 no decode while enable is zero
    inj(1'b1, TGT, 4'hF, 32'd1, c); chk("R6 disabled claim", c, 0);
    rd(A_ST, v); chk("R6 disabled status", v, 0);

    // R9 enable/mask readback, unmapped offsets
    wr(A_EN, 32'hA5A5_0F0F); rd(A_EN, v); chk("R9 enable readback", v, 32'hA5A5_0F0F);
    wr(A_MK, 32'h1234_5678); rd(A_MK, v); chk("R9 mask readback", v, 32'h1234_5678);
    wr(12'h834, 32'hFFFF_FFFF);
    rd(12'h834, v); chk("R9 unmapped read", v, 0);
    rd(A_EN, v); chk("R9 unmapped write enable", v, 32'hA5A5_0F0F);
    rd(A_MK, v); chk("R9 unmapped write mask", v, 32'h1234_5678);
    rd(A_ST, v); chk("R9 unmapped write status", v, 0);
    rd(A_LO, v); chk("R9 unmapped write addr", v, TGT[31:0]);

    // R3 R4 table walk
    for (int i = 0; i < 7; i++) begin
      clear_status();
      chk("R5 irq cleared before vector", irq, 0);
      wr(A_EN, VEC[i][128:97]);
      wr(A_MK, VEC[i][96:65]);
      inj(1'b1, TGT, 4'hF, VEC[i][64:33], c);
      chk("R3 table claim", c, 1);
      rd(A_ST, v); chk("R3 table status", v, VEC[i][32:1]);
      chk("R4 table irq", irq, VEC[i][0]);
    end
    clear_status();

    // R6 window follows a rewritten address
    wr(A_EN, 32'hFFFF_FFFF); wr(A_MK, 32'h0);
    wr(A_LO, 32'hFEE0_2000);
    inj(1'b1, TGT, 4'hF, 32'd7, c); chk("R6 old address claim", c, 0);
    inj(1'b1, {TGT[63:32], 32'hFEE0_2000}, 4'hF, 32'd7, c); chk("R6 new address claim", c, 1);
    rd(A_ST, v); chk("R6 new address status", v, 32'h80);
    wr(A_LO, TGT[31:0]);
    clear_status();

    // R7 alignment and byte enables
    inj(1'b1, TGT + 64'd2, 4'hF, 32'd1, c); chk("R7 unaligned claim", c, 0);
    inj(1'b1, TGT, 4'h3, 32'd1, c); chk("R7 partial be claim", c, 0);
    rd(A_ST, v); chk("R7 status untouched", v, 0);
    chk("R7 irq untouched", irq, 0);

    // R8 reads pass through
    inj(1'b0, TGT, 4'hF, 32'd1, c); chk("R8 read claim", c, 0);
    rd(A_ST, v); chk("R8 status untouched", v, 0);

    // R5 toggling and interrupt release
    inj(1'b1, TGT, 4'hF, 32'd2, c);
    inj(1'b1, TGT, 4'hF, 32'd3, c);
    rd(A_ST, v); chk("R5 two pending", v, 32'hC);
    chk("R5 irq up", irq, 1);
    wr(A_ST, 32'h4);
    rd(A_ST, v); chk("R5 toggle one", v, 32'h8);
    chk("R5 irq held nonzero", irq, 1);
    wr(A_ST, 32'h8);
    rd(A_ST, v); chk("R5 all clear", v, 0);
    chk("R5 irq released", irq, 0);
    wr(A_ST, 32'h1);
    rd(A_ST, v); chk("R5 software set", v, 32'h1);
    chk("R5 software no irq", irq, 0);

    // R1 reset again mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(A_ST, v); chk("R1 reset status", v, 0);
    rd(A_EN, v); chk("R1 reset enable", v, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule